// File: doc/BRIEF.md
# MSI Capture Queue with APB Register Slave

This block sits beside the inbound path of a PCIe root-complex bridge and watches memory writes arriving from endpoints. Software programs a 64-bit window base and a 32-bit window size, then sets an enable flag. From then on, every inbound write that lands inside the window is stored as one queue entry. An entry holds the 32-bit write data and the full 64-bit write address. By convention an endpoint raises vector n by writing the value n to window base + 4·n, so the data word identifies the vector and the address confirms it.

Software reaches the queue through an APB register slave. A level interrupt line and a pending flag in the status register both show that entries are waiting. A handler drains the queue by reading, in a loop, the captured data word, then the low address word, then the high address word, then the status register. It stops once the pending flag reads 0.

A small state machine follows the three reads that retire an entry. SEQ_WAIT_DATA moves to SEQ_WAIT_ALO when the data register is read. SEQ_WAIT_ALO moves to SEQ_WAIT_AHI when the low address register is read. SEQ_WAIT_AHI returns to SEQ_WAIT_DATA when the high address register is read, and that read pops the head entry. Any other read leaves the state where it is, and no transition is taken while the queue is empty.

Top module: `msi_capture_ctrl`

## Requirements
- R1: With enable (offset 0x14 bit 0) set to 1, an inbound write whose address A satisfies base <= A < base+size is stored with its data and 64-bit address. Base comes from 0x04 (low word) and 0x08 (high word), and size comes from 0x0C. All three registers read back what was written, and they reset to 0.
- R2: An inbound write is ignored and leaves the queue unchanged when enable is 0, when A < base, or when A >= base+size.
- R3: Status (0x18) bit 0 reads 1 while at least one entry is queued and 0 when the queue is empty.
- R4: The head entry is popped only by reading data (0x20), then address low (0x24), then address high (0x28), in that order. Reading data alone, or reading address low before data, does not advance the sequence.
- R5: A write that hits the window while the queue holds FIFO_DEPTH entries (default 16) is dropped unless a pop happens in the same cycle. A dropped write sets status bit 1, which stays set until software writes 1 to that bit.
- R6: When a capture and a pop happen in the same cycle, both take effect and the entry count is unchanged.
- R7: Reading 0x20, 0x24 or 0x28 while the queue is empty returns 0 and changes no state.
- R8: msi_irq equals status bit 0. It falls in the cycle after the access cycle of the pop that empties the queue.
- R9: Entries leave the queue in arrival order. Reads of 0x20, 0x24 and 0x28 return the head entry's data, address bits 31:0 and address bits 63:32.
- R10: Writing value n to base + 4·n for n = 0..15 yields 16 entries whose data words read back as 0..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| in_wr_valid | input | 1 | An inbound memory write is present this cycle |
| in_wr_addr | input | 64 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data |
| msi_irq | output | 1 | Level interrupt, high while entries are queued |

## Verification
The checker tests several properties on every clock. A simultaneous capture and pop keeps the count. A window hit on a full queue without a pop sets the overflow flag and is dropped. No pop happens while the queue is empty, and nothing is pushed while capture is disabled. The count never exceeds the depth, and the interrupt clears right after the final pop. Some behaviours depend on register programming and read order, and only the bench's scenarios can show them: which addresses fall inside the window, that the drain order is arrival order, that out-of-order or repeated reads leave the head entry in place, that empty reads return 0, and that the overflow flag clears on a write of 1.

// File: rtl/msicap_pkg.sv
package msicap_pkg;

    localparam int DATA_W = 32;
    localparam int MADDR_W = 64;

    localparam logic [7:0] OFF_WIN_LO  = 8'h04;
    localparam logic [7:0] OFF_WIN_HI  = 8'h08;
    localparam logic [7:0] OFF_WIN_SZ  = 8'h0C;
    localparam logic [7:0] OFF_CAP_EN  = 8'h14;
    localparam logic [7:0] OFF_STAT    = 8'h18;
    localparam logic [7:0] OFF_Q_DATA  = 8'h20;
    localparam logic [7:0] OFF_Q_ALO   = 8'h24;
    localparam logic [7:0] OFF_Q_AHI   = 8'h28;

    typedef struct packed {
        logic [DATA_W-1:0]  data;
        logic [MADDR_W-1:0] addr;
    } msg_entry_t;

    typedef enum logic [1:0] {
        SEQ_WAIT_DATA = 2'd0,
        SEQ_WAIT_ALO  = 2'd1,
        SEQ_WAIT_AHI  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/msicap_window.sv
module msicap_window
    import msicap_pkg::*;
(
    input  logic               cap_en,
    input  logic [MADDR_W-1:0] win_base,
    input  logic [DATA_W-1:0]  win_size,
    input  logic               wr_valid,
    input  logic [MADDR_W-1:0] wr_addr,
    output logic               hit
);
    logic [MADDR_W-1:0] offset;
    logic               above_base;
    logic               below_top;

    always_comb begin
        offset     = wr_addr - win_base;
        above_base = (wr_addr >= win_base);
        below_top  = (offset < {{(MADDR_W-DATA_W){1'b0}}, win_size});
        hit        = wr_valid && cap_en && above_base && below_top;
    end
endmodule

// File: rtl/msicap_fifo.sv
module msicap_fifo
    import msicap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  msg_entry_t                    push_entry,
    input  logic                          pop,
    output msg_entry_t                    head,
    output logic                          empty,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    msg_entry_t       store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        head  = store[rd_ptr];
        count = cnt_q;
        empty = (cnt_q == '0);
        full  = (cnt_q == CNT_W'(DEPTH));
    end
endmodule

// File: rtl/msicap_popseq.sv
module msicap_popseq
    import msicap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_data,
    input  logic       rd_alo,
    input  logic       rd_ahi,
    input  logic       q_empty,
    output logic       pop,
    output seq_state_e state
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAIT_DATA;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_WAIT_DATA: if (rd_data && !q_empty) state_d = SEQ_WAIT_ALO;
            SEQ_WAIT_ALO:  if (rd_alo  && !q_empty) state_d = SEQ_WAIT_AHI;
            SEQ_WAIT_AHI:  if (rd_ahi  && !q_empty) state_d = SEQ_WAIT_DATA;
            default:                                state_d = SEQ_WAIT_DATA;
        endcase
    end

    always_comb begin
        pop   = (state_q == SEQ_WAIT_AHI) && rd_ahi && !q_empty;
        state = state_q;
    end
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msicap_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int PADDR_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    input  logic               in_wr_valid,
    input  logic [63:0]        in_wr_addr,
    input  logic [31:0]        in_wr_data,
    output logic               msi_irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [MADDR_W-1:0] win_base_q;
    logic [DATA_W-1:0]  win_size_q;
    logic               cap_en_q;
    logic               ovf_q;

    logic               apb_wr;
    logic               apb_rd;
    logic               cap_hit;
    logic               push;
    logic               pop;
    logic               q_empty;
    logic               q_full;
    logic [CNT_W-1:0]   q_count;
    msg_entry_t         head;
    msg_entry_t         new_entry;
    seq_state_e         seq_state;

    function automatic logic at(input logic [PADDR_W-1:0] a, input logic [7:0] off);
        return a == PADDR_W'(off);
    endfunction

    always_comb begin
        apb_wr         = psel && penable && pwrite;
        apb_rd         = psel && penable && !pwrite;
        new_entry.data = in_wr_data;
        new_entry.addr = in_wr_addr;
        push           = cap_hit && (!q_full || pop);
    end

    msicap_window u_window (
        .cap_en   (cap_en_q),
        .win_base (win_base_q),
        .win_size (win_size_q),
        .wr_valid (in_wr_valid),
        .wr_addr  (in_wr_addr),
        .hit      (cap_hit)
    );

    msicap_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (new_entry),
        .pop        (pop),
        .head       (head),
        .empty      (q_empty),
        .full       (q_full),
        .count      (q_count)
    );

    msicap_popseq u_popseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_data (apb_rd && at(paddr, OFF_Q_DATA)),
        .rd_alo  (apb_rd && at(paddr, OFF_Q_ALO)),
        .rd_ahi  (apb_rd && at(paddr, OFF_Q_AHI)),
        .q_empty (q_empty),
        .pop     (pop),
        .state   (seq_state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base_q <= '0;
            win_size_q <= '0;
            cap_en_q   <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            if (apb_wr && at(paddr, OFF_WIN_LO)) win_base_q[31:0]  <= pwdata;
            if (apb_wr && at(paddr, OFF_WIN_HI)) win_base_q[63:32] <= pwdata;
            if (apb_wr && at(paddr, OFF_WIN_SZ)) win_size_q        <= pwdata;
            if (apb_wr && at(paddr, OFF_CAP_EN)) cap_en_q          <= pwdata[0];
            if (cap_hit && q_full && !pop) begin
                ovf_q <= 1'b1;
            end else if (apb_wr && at(paddr, OFF_STAT) && pwdata[1]) begin
                ovf_q <= 1'b0;
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (at(paddr, OFF_WIN_LO)) prdata = win_base_q[31:0];
            if (at(paddr, OFF_WIN_HI)) prdata = win_base_q[63:32];
            if (at(paddr, OFF_WIN_SZ)) prdata = win_size_q;
            if (at(paddr, OFF_CAP_EN)) prdata = {31'd0, cap_en_q};
            if (at(paddr, OFF_STAT))   prdata = {30'd0, ovf_q, !q_empty};
            if (!q_empty) begin
                if (at(paddr, OFF_Q_DATA)) prdata = head.data;
                if (at(paddr, OFF_Q_ALO))  prdata = head.addr[31:0];
                if (at(paddr, OFF_Q_AHI))  prdata = head.addr[63:32];
            end
        end
        msi_irq = !q_empty;
    end
endmodule

// File: rtl/msicap_checker.sv
module msicap_checker #(
    parameter int FIFO_DEPTH = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cap_en_q,
    input logic                           cap_hit,
    input logic                           push,
    input logic                           pop,
    input logic                           q_full,
    input logic                           q_empty,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] q_count,
    input logic                           ovf_q,
    input logic                           msi_irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    a_r6_push_pop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> q_count == $past(q_count));

    a_r5_full_hit_drops: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit && q_full && !pop |=> ovf_q && q_count == $past(q_count));

    a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(FIFO_DEPTH));

    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty |-> !pop);

    a_r2_disabled_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_q |-> !push);

    a_r8_irq_drops_after_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && q_count == CNT_W'(1) |=> !msi_irq);
endmodule

bind msi_capture_ctrl msicap_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_msicap_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en_q (cap_en_q),
    .cap_hit  (cap_hit),
    .push     (push),
    .pop      (pop),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .q_count  (q_count),
    .ovf_q    (ovf_q),
    .msi_irq  (msi_irq)
);

// File: tb/msi_capture_ctrl_bench.sv
`timescale 1ns/1ps
module msi_capture_ctrl_bench;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    msi_capture_ctrl #(.FIFO_DEPTH(DEPTH), .PADDR_W(8)) u_msi_capture_ctrl (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata),
        .in_wr_valid(wr_valid), .in_wr_addr(wr_addr), .in_wr_data(wr_data),
        .msi_irq(irq)
    );

    // Behavioural reference model
    typedef struct { logic [31:0] d; logic [63:0] a; } ment_t;
    ment_t       mq[$];
    logic [63:0] m_base;
    logic [31:0] m_size;
    logic        m_en;
    logic        m_ovf;
    int          m_seq;
    logic        m_pop;
    logic        m_hit;
    logic        m_set;
    logic        m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_base = '0; m_size = '0; m_en = 0; m_ovf = 0; m_seq = 0;
        end else begin
            m_acc = psel && penable;
            m_pop = 0;
            m_set = 0;
            if (m_acc && !pwrite && mq.size() > 0) begin
                if (m_seq == 0 && paddr == 8'h20) m_seq = 1;
                else if (m_seq == 1 && paddr == 8'h24) m_seq = 2;
                else if (m_seq == 2 && paddr == 8'h28) begin m_seq = 0; m_pop = 1; end
            end
            m_hit = wr_valid && m_en && (wr_addr >= m_base)
                    && ((wr_addr - m_base) < {32'd0, m_size});
            if (m_pop) void'(mq.pop_front());
            if (m_hit) begin
                if (mq.size() < DEPTH) mq.push_back('{d: wr_data, a: wr_addr});
                else m_set = 1;
            end
            if (m_acc && pwrite) begin
                case (paddr)
                    8'h04: m_base[31:0]  = pwdata;
                    8'h08: m_base[63:32] = pwdata;
                    8'h0C: m_size        = pwdata;
                    8'h14: m_en          = pwdata[0];
                    8'h18: if (pwdata[1]) m_ovf = 0;
                    default: ;
                endcase
            end
            if (m_set) m_ovf = 1;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h04: return m_base[31:0];
            8'h08: return m_base[63:32];
            8'h0C: return m_size;
            8'h14: return {31'd0, m_en};
            8'h18: return {30'd0, m_ovf, mq.size() > 0};
            8'h20: return (mq.size() > 0) ? mq[0].d : 32'd0;
            8'h24: return (mq.size() > 0) ? mq[0].a[31:0] : 32'd0;
            8'h28: return (mq.size() > 0) ? mq[0].a[63:32] : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R3 R8: interrupt line follows the model's pending state every cycle
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) chk("R8 irq level", {31'd0, irq}, {31'd0, mq.size() > 0});
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input string tag, output logic [31:0] v,
                          input bit cw = 0, input logic [63:0] wa = '0, input logic [31:0] wd = '0);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        if (cw) begin wr_valid = 1; wr_addr = wa; wr_data = wd; end
        #1;
        v = prdata;
        chk(tag, v, model_read(a));
        @(negedge clk); psel = 0; penable = 0; wr_valid = 0;
    endtask

    task automatic inbound(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_valid = 0;
    endtask

    localparam logic [63:0] BASE = 64'h0000_0001_2000_0000;

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // Reset state
        apb_rd(8'h04, "R1 base lo reset", v);  chk("R1 base lo zero", v, 32'd0);
        apb_rd(8'h0C, "R1 size reset", v);
        apb_rd(8'h18, "R3 status reset", v);   chk("R3 status zero", v, 32'd0);
        apb_rd(8'h20, "R7 empty data", v);     chk("R7 empty data zero", v, 32'd0);
        apb_rd(8'h28, "R7 empty ahi", v);

        // Program window, capture disabled
        apb_wr(8'h04, BASE[31:0]);
        apb_wr(8'h08, BASE[63:32]);
        apb_wr(8'h0C, 32'd4096);
        apb_rd(8'h08, "R1 base hi readback", v); chk("R1 base hi value", v, 32'h1);
        inbound(BASE + 64'd8, 32'd2);
        apb_rd(8'h18, "R2 disabled ignored", v); chk("R2 disabled status", v, 32'd0);

        apb_wr(8'h14, 32'd1);
        apb_rd(8'h14, "R1 enable readback", v);
        inbound(BASE - 64'd4, 32'hAA);
        inbound(BASE + 64'd4096, 32'hBB);
        apb_rd(8'h18, "R2 outside window", v); chk("R2 outside status", v, 32'd0);

        // Fill with vectors 0..15, then overflow
        for (int n = 0; n < DEPTH; n++) inbound(BASE + 64'(4 * n), 32'(n));
        apb_rd(8'h18, "R3 pending", v); chk("R3 pending value", v, 32'd1);
        inbound(BASE + 64'd4092, 32'hDEAD);
        apb_rd(8'h18, "R5 overflow set", v); chk("R5 overflow value", v, 32'd3);
        apb_wr(8'h18, 32'd1);
        apb_rd(8'h18, "R5 write 1 to bit0 no clear", v);
        apb_wr(8'h18, 32'd2);
        apb_rd(8'h18, "R5 overflow cleared", v); chk("R5 cleared value", v, 32'd1);

        // Out of order and repeated reads do not pop
        apb_rd(8'h24, "R4 alo before data", v);
        apb_rd(8'h28, "R4 ahi before data", v);
        apb_rd(8'h20, "R4 data only", v);      chk("R4 head still 0", v, 32'd0);
        apb_rd(8'h28, "R4 ahi skip alo", v);
        apb_rd(8'h20, "R4 data again", v);     chk("R4 head still 0 again", v, 32'd0);

        // Drain in order (sequence is now at address-low)
        for (int n = 0; n < DEPTH; n++) begin
            if (n != 0) begin
                apb_rd(8'h20, "R9 data", v); chk("R10 vector data", v, 32'(n));
            end
            apb_rd(8'h24, "R9 addr lo", v); chk("R10 vector addr", v, BASE[31:0] + 32'(4 * n));
            apb_rd(8'h28, "R9 addr hi", v); chk("R9 addr hi value", v, 32'h1);
            apb_rd(8'h18, "R3 status during drain", v);
        end
        apb_rd(8'h18, "R3 drained", v); chk("R8 drained status", v, 32'd0);
        apb_rd(8'h24, "R7 empty alo", v); chk("R7 empty alo zero", v, 32'd0);

        // Simultaneous capture and pop
        inbound(BASE + 64'd20, 32'd5);
        apb_rd(8'h20, "R6 data", v);
        apb_rd(8'h24, "R6 alo", v);
        apb_rd(8'h28, "R6 ahi with capture", v, 1'b1, BASE + 64'd28, 32'd7);
        apb_rd(8'h18, "R6 still pending", v); chk("R6 status", v, 32'd1);
        apb_rd(8'h20, "R6 new head", v);      chk("R6 new head value", v, 32'd7);

        // Full queue plus pop in the same cycle: no loss
        apb_rd(8'h24, "R6 alo b", v);
        apb_rd(8'h28, "R6 ahi b", v);
        for (int n = 0; n < DEPTH; n++) inbound(BASE + 64'(4 * n), 32'(n + 100));
        apb_rd(8'h20, "R6 full data", v);
        apb_rd(8'h24, "R6 full alo", v);
        apb_rd(8'h28, "R6 full pop+push", v, 1'b1, BASE + 64'd60, 32'd999);
        apb_rd(8'h18, "R5 no overflow on pop", v); chk("R5 no ovf value", v, 32'd1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule